// File: doc/BRIEF.md
# Edge-Capture Timer Channel

An 8-bit up-counting timer channel for a small controller's peripheral bus. A prescaler, chosen by a select field, turns the system clock into count ticks. The select field can also pick a divided-down rate or a synchronized external clock pin. The count is compared against a compare register. When a tick would make the count equal to the compare value, the count returns to zero and a sticky timer flag is raised. Software can therefore count these periods.

In capture mode, a chosen transition on the capture pin does three things. It stores the live count in a capture register, it restarts the count and the prescaler from zero, and it raises a sticky external-event flag. Compare matches keep firing in capture mode. A pulse longer than one compare period can therefore be measured as a number of periods plus the captured remainder. Reads and writes at the data address reach different registers: writes load the compare value, and reads return the captured value in capture mode or the live count in timer mode.

Top module: `cap_timer`

## Requirements
- R1: After reset, all four addresses read 0, the count is 0, the channel is stopped and both interrupt outputs are low.
- R2: Control bits [2:0] select the tick rate. The codes 0 to 6 divide the clock by 2, 4, 8, 32, 128, 512 and 2048. After a start, the count is the number of whole divide periods elapsed.
- R3: Select code 7 advances the count once per rising edge of the external clock pin. That pin passes through a two-flop synchronizer.
- R4: When a tick would make the count equal the compare value, the count becomes 0 and the timer flag is set. A compare value of 0 gives a period of 256 ticks.
- R5: Writing control (address 0) with bit 3 set clears the count and the prescaler and starts counting. Writing it with bit 3 clear freezes the count.
- R6: With control bit 4 set (capture mode), a qualifying capture-pin edge copies the count into the capture register, clears the count and prescaler, and sets the external flag. The copy lands on the third clock edge after the pin changes.
- R7: Edge select (address 2, bits [1:0]) chooses which capture-pin edges qualify: 00 none, 01 falling, 10 rising, 11 both.
- R8: In timer mode a qualifying edge sets the external flag but leaves the count and capture register untouched.
- R9: Writes to address 1 load only the compare register. Reads of address 1 return the capture register in capture mode and the live count in timer mode.
- R10: Flags (address 3: bit 0 timer, bit 1 external) stay set until software writes 1 to the bit.
- R11: Compare matches continue to set the timer flag in capture mode.
- R12: If a capture and a prescaler tick fall in the same cycle, the capture wins. The captured value is the count before that tick, and the count restarts at 0.
- R13: `tmr_irq_o` and `ext_irq_o` follow the timer and external flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_i | input | 1 | External count clock (asynchronous) |
| cap_pin_i | input | 1 | Capture pin (asynchronous) |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data (combinational from address) |
| tmr_irq_o | output | 1 | Timer flag |
| ext_irq_o | output | 1 | External-event flag |

## Verification
The assertions assume the capture and external-clock pins change no faster than once every few clocks, so that each transition yields a single synchronized pulse. They also assume that software does not write control with the start bit in the same cycle as a capture. The stimulus changes both pins only on falling clock edges and holds each level for at least three cycles. It issues register writes only between capture events whose timing is counted exactly, so no start write ever coincides with a capture.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int          ADDR_W = 2;
   localparam logic [1:0]  A_CTRL = 2'd0;
   localparam logic [1:0]  A_DATA = 2'd1;
   localparam logic [1:0]  A_EDGE = 2'd2;
   localparam logic [1:0]  A_FLAG = 2'd3;
   localparam int          SEL_W  = 3;
   localparam int          B_RUN  = 3;
   localparam int          B_CAPM = 4;
   localparam int          CTRL_W = 5;
   localparam int          F_TMR  = 0;
   localparam int          F_EXT  = 1;
   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_FALL = 2'b01,
      EDGE_RISE = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_mode_e;
endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
   parameter int SYNC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_i,
   input  logic [1:0] mode_i,
   output logic       hit_o
);
   if (SYNC < 2) begin : g_bad_sync
      $error("tmr_edge_det: SYNC must be at least 2");
   end

   logic [SYNC:0] sh_q;
   logic          now_s, was_s, rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SYNC-1:0], pin_i};
   end

   assign now_s = sh_q[SYNC-1];
   assign was_s = sh_q[SYNC];
   assign rise  = now_s & ~was_s;
   assign fall  = ~now_s & was_s;
   assign hit_o = (mode_i[1] & rise) | (mode_i[0] & fall);

   // R7: an edge yields one pulse; the stored sample catches up next cycle
   p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> !hit_o);
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int VARIANT = 0,
   parameter int SYNC    = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      run_i,
   input  logic                      clr_i,
   input  logic [tmr_pkg::SEL_W-1:0] sel_i,
   input  logic                      ext_clk_i,
   output logic                      tick_o
);
   if (VARIANT < 0 || VARIANT > 1) begin : g_bad_var
      $error("tmr_prescale: VARIANT must be 0 or 1");
   end

   localparam int PRE_W = (VARIANT == 0) ? 11 : 3;

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pre_q <= '0;
      else if (clr_i)  pre_q <= '0;
      else if (run_i)  pre_q <= pre_q + 1'b1;
   end

   if (VARIANT == 0) begin : g_wide
      logic ext_rise;
      tmr_edge_det #(.SYNC(SYNC)) u_ext (
         .clk   (clk),
         .rst_n (rst_n),
         .pin_i (ext_clk_i),
         .mode_i(2'b10),
         .hit_o (ext_rise)
      );
      always_comb begin
         case (sel_i)
            3'd0:    mask = 11'h001;
            3'd1:    mask = 11'h003;
            3'd2:    mask = 11'h007;
            3'd3:    mask = 11'h01F;
            3'd4:    mask = 11'h07F;
            3'd5:    mask = 11'h1FF;
            3'd6:    mask = 11'h7FF;
            default: mask = '0;
         endcase
      end
      assign tick_o = run_i && ((sel_i == 3'd7) ? ext_rise
                                                : ((pre_q & mask) == mask));
      // R5: a stopped channel never ticks
      p_no_tick_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
         !run_i |-> !tick_o);
   end else begin : g_small
      always_comb begin
         case (sel_i[1:0])
            2'd0:    mask = 3'h0;
            2'd1:    mask = 3'h1;
            default: mask = 3'h7;
         endcase
      end
      assign tick_o = run_i && ((pre_q & mask) == mask);
   end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic         cap_i,
   input  logic         start_i,
   input  logic [W-1:0] cmp_i,
   output logic [W-1:0] cnt_o,
   output logic [W-1:0] capv_o,
   output logic         match_o
);
   logic [W-1:0] cnt_q, capv_q, nxt;

   assign nxt     = cnt_q + 1'b1;
   assign match_o = tick_i && !cap_i && !start_i && (nxt == cmp_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         capv_q <= '0;
      end else if (start_i) begin
         cnt_q  <= '0;
      end else if (cap_i) begin
         capv_q <= cnt_q;
         cnt_q  <= '0;
      end else if (tick_i) begin
         cnt_q  <= (nxt == cmp_i) ? '0 : nxt;
      end
   end

   assign cnt_o  = cnt_q;
   assign capv_o = capv_q;

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !cap_i && !start_i) |=> $stable(cnt_q));
   p_step_or_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !cap_i && !start_i) |=>
         ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0)));
   p_capture_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_i && !start_i) |=> (cnt_q == '0) && (capv_q == $past(cnt_q)));
endmodule

// File: rtl/cap_timer.sv
module cap_timer #(
   parameter int CNT_W       = 8,
   parameter int VARIANT     = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ext_clk_i,
   input  logic                      cap_pin_i,
   input  logic                      bus_wr_i,
   input  logic [tmr_pkg::ADDR_W-1:0] bus_addr_i,
   input  logic [CNT_W-1:0]          bus_wdata_i,
   output logic [CNT_W-1:0]          bus_rdata_o,
   output logic                      tmr_irq_o,
   output logic                      ext_irq_o
);
   import tmr_pkg::*;

   if (CNT_W < CTRL_W) begin : g_bad_w
      $error("cap_timer: CNT_W must hold the control field");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [1:0]        edge_q;
   logic [CNT_W-1:0]  cmp_q, cnt, capv;
   logic              tmr_f, ext_f;
   logic              wr_ctrl, wr_cmp, wr_edge, wr_flag;
   logic              start, hit, cap, tick, match;

   assign wr_ctrl = bus_wr_i && (bus_addr_i == A_CTRL);
   assign wr_cmp  = bus_wr_i && (bus_addr_i == A_DATA);
   assign wr_edge = bus_wr_i && (bus_addr_i == A_EDGE);
   assign wr_flag = bus_wr_i && (bus_addr_i == A_FLAG);
   assign start   = wr_ctrl && bus_wdata_i[B_RUN];
   assign cap     = hit && ctrl_q[B_CAPM];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         edge_q <= EDGE_OFF;
         cmp_q  <= '0;
         tmr_f  <= 1'b0;
         ext_f  <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= bus_wdata_i[CTRL_W-1:0];
         if (wr_cmp)  cmp_q  <= bus_wdata_i;
         if (wr_edge) edge_q <= bus_wdata_i[1:0];
         tmr_f <= match | (tmr_f & ~(wr_flag & bus_wdata_i[F_TMR]));
         ext_f <= hit   | (ext_f & ~(wr_flag & bus_wdata_i[F_EXT]));
      end
   end

   tmr_edge_det #(.SYNC(SYNC_STAGES)) u_cap_det (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (cap_pin_i),
      .mode_i(edge_q),
      .hit_o (hit)
   );

   tmr_prescale #(.VARIANT(VARIANT), .SYNC(SYNC_STAGES)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (ctrl_q[B_RUN]),
      .clr_i    (start | cap),
      .sel_i    (ctrl_q[SEL_W-1:0]),
      .ext_clk_i(ext_clk_i),
      .tick_o   (tick)
   );

   tmr_count #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick),
      .cap_i  (cap),
      .start_i(start),
      .cmp_i  (cmp_q),
      .cnt_o  (cnt),
      .capv_o (capv),
      .match_o(match)
   );

   always_comb begin
      bus_rdata_o = '0;
      case (bus_addr_i)
         A_CTRL:  bus_rdata_o[CTRL_W-1:0] = ctrl_q;
         A_DATA:  bus_rdata_o = ctrl_q[B_CAPM] ? capv : cnt;
         A_EDGE:  bus_rdata_o[1:0] = edge_q;
         default: bus_rdata_o[1:0] = {ext_f, tmr_f};
      endcase
   end

   assign tmr_irq_o = tmr_f;
   assign ext_irq_o = ext_f;

   p_tmr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_f && !(wr_flag && bus_wdata_i[F_TMR])) |=> tmr_f);
   p_ext_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_f && !(wr_flag && bus_wdata_i[F_EXT])) |=> ext_f);
   p_match_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> tmr_irq_o);
endmodule

// File: tb/sim_cap_timer.sv
module sim_cap_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_clk = 1'b0;
   logic       cap_pin = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       tmr_irq, ext_irq;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   cap_timer u0 (
      .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .cap_pin_i(cap_pin),
      .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
      .bus_rdata_o(bus_rdata), .tmr_irq_o(tmr_irq), .ext_irq_o(ext_irq)
   );

   // {select code, cycles after start, expected count}   (R2)
   localparam logic [31:0] VEC [8] = '{
      {8'd0, 16'd9,    8'd4},
      {8'd1, 16'd13,   8'd3},
      {8'd2, 16'd39,   8'd4},
      {8'd2, 16'd40,   8'd5},
      {8'd3, 16'd100,  8'd3},
      {8'd4, 16'd300,  8'd2},
      {8'd5, 16'd1100, 8'd2},
      {8'd6, 16'd4200, 8'd2}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v); chk("R1 reset read", v, 8'h00);
      end
      chk("R1 tmr_irq", {7'd0, tmr_irq}, 8'd0);
      chk("R1 ext_irq", {7'd0, ext_irq}, 8'd0);
      // R9 compare is write-only; timer-mode read shows the stopped count
      wr(2'd1, 8'h5A);
      rd(2'd1, v); chk("R9 read after compare write", v, 8'h00);

      // R2 prescale table
      for (int i = 0; i < 8; i++) begin
         wr(2'd1, 8'h00);
         wr(2'd0, VEC[i][31:24] | 8'h08);
         idle(int'(VEC[i][23:8]));
         rd(2'd1, v); chk("R2 prescale count", v, VEC[i][7:0]);
      end

      // R3 external clock
      wr(2'd0, 8'h0F);
      for (int k = 0; k < 5; k++) begin
         ext_clk = 1'b1; idle(4);
         ext_clk = 1'b0; idle(4);
      end
      idle(4);
      rd(2'd1, v); chk("R3 external count", v, 8'd5);

      // R5 stop and restart
      wr(2'd0, 8'h08);
      idle(10);
      rd(2'd1, v); chk("R5 running count", v, 8'd5);
      wr(2'd0, 8'h00);
      idle(20);
      rd(2'd1, v); chk("R5 frozen count", v, 8'd5);
      wr(2'd0, 8'h08);
      rd(2'd1, v); chk("R5 restart clears", v, 8'd0);

      // R4 compare match in timer mode, R10 sticky flag, R13
      wr(2'd3, 8'h03);
      wr(2'd1, 8'd3);
      wr(2'd0, 8'h08);
      idle(5);
      rd(2'd1, v); chk("R4 count before match", v, 8'd2);
      chk("R4 flag before match", {7'd0, tmr_irq}, 8'd0);
      idle(1);
      rd(2'd1, v); chk("R4 count wraps at match", v, 8'd0);
      chk("R13 tmr_irq on match", {7'd0, tmr_irq}, 8'd1);
      idle(30);
      rd(2'd3, v); chk("R10 timer flag sticky", v, 8'h01);
      wr(2'd3, 8'h01);
      chk("R10 timer flag cleared", {7'd0, tmr_irq}, 8'd0);
      // R4 compare 0 gives 256-tick period
      wr(2'd1, 8'd0);
      wr(2'd0, 8'h08);
      idle(511);
      rd(2'd1, v); chk("R4 count 255", v, 8'd255);
      chk("R4 no flag before wrap", {7'd0, tmr_irq}, 8'd0);
      idle(1);
      rd(2'd1, v); chk("R4 wrap to 0", v, 8'd0);
      chk("R4 flag at wrap", {7'd0, tmr_irq}, 8'd1);

      // R6 / R12 capture on both edges
      wr(2'd3, 8'h03);
      wr(2'd2, 8'h03);
      wr(2'd0, 8'h18);
      idle(19);
      cap_pin = 1'b1;
      idle(2);
      chk("R6 no capture yet", {7'd0, ext_irq}, 8'd0);
      idle(1);
      rd(2'd1, v); chk("R12 capture beats tick", v, 8'd10);
      chk("R6 ext flag on capture", {7'd0, ext_irq}, 8'd1);
      wr(2'd3, 8'h02);
      idle(27);
      cap_pin = 1'b0;
      idle(3);
      rd(2'd1, v); chk("R6 count restarted", v, 8'd15);
      chk("R13 ext_irq on capture", {7'd0, ext_irq}, 8'd1);

      // R11 compare match in capture mode
      wr(2'd3, 8'h03);
      wr(2'd1, 8'd4);
      wr(2'd0, 8'h18);
      idle(7);
      chk("R11 no match yet", {7'd0, tmr_irq}, 8'd0);
      idle(1);
      chk("R11 match in capture mode", {7'd0, tmr_irq}, 8'd1);

      // R8 edge in timer mode
      wr(2'd1, 8'd0);
      wr(2'd3, 8'h03);
      wr(2'd2, 8'h02);
      wr(2'd0, 8'h08);
      idle(9);
      cap_pin = 1'b1;
      idle(3);
      chk("R8 ext flag in timer mode", {7'd0, ext_irq}, 8'd1);
      rd(2'd1, v); chk("R8 count untouched", v, 8'd6);
      cap_pin = 1'b0;
      idle(2);
      rd(2'd1, v); chk("R8 count continues", v, 8'd7);
      idle(5);

      // R7 falling-only and off modes
      wr(2'd3, 8'h03);
      wr(2'd2, 8'h01);
      wr(2'd0, 8'h18);
      idle(5);
      cap_pin = 1'b1;
      idle(5);
      chk("R7 rise ignored in falling mode", {7'd0, ext_irq}, 8'd0);
      rd(2'd1, v); chk("R7 capture unchanged", v, 8'd15);
      cap_pin = 1'b0;
      idle(3);
      rd(2'd1, v); chk("R7 falling capture", v, 8'd6);
      chk("R7 falling sets flag", {7'd0, ext_irq}, 8'd1);
      wr(2'd2, 8'h00);
      wr(2'd3, 8'h03);
      cap_pin = 1'b1; idle(5);
      cap_pin = 1'b0; idle(5);
      chk("R7 off mode ignores edges", {7'd0, ext_irq}, 8'd0);
      rd(2'd1, v); chk("R7 off mode keeps capture", v, 8'd6);

      finish_run();
   end
endmodule